// File: doc/BRIEF.md
# Memory Write Fault-Injection Matcher

This block sits next to one channel's memory write path and corrupts chosen writes on purpose so that error-handling logic can be exercised. Software loads three registers through a small write port. The first is a match word that holds target values for the DIMM, rank, bank, page and column fields, plus one ignore flag per field. The second is a mask of ECC bits to invert. The third is a control word that selects the error kind, the half-cacheline and repeat behaviour.

Each write presented on the address side is compared against the match word. A write fires the injector only when every field that is not ignored is equal and the block is armed. In the cycle after the write, the block drives the ECC flip mask, a parity-corrupt strobe, the half-cacheline select and a fire pulse. It also flags a mask whose flips span more than one aligned 16-bit symbol pair, because that mask produces an uncorrectable error. How the rank and DIMM bits share the match word depends on whether the channel holds more than two DIMMs.

Top module: `memfault_inject_unit`

## Requirements
- R1: After reset, `inj_fire`, `flip_mask`, `parity_corrupt`, `half_sel`, `uncorrectable`, `armed` and `fired` are all zero.
- R2: Column is compared against match bits 13:0, page against bits 29:14 and bank against bits 33:30. A field that differs blocks the injection.
- R3: With `three_dimm`=1, rank bit 0 is compared against match bit 34 and DIMM bits 1:0 against bits 36:35. With `three_dimm`=0, rank bits 1:0 are compared against bits 35:34 and DIMM bit 0 against bit 36. The bits left over in each layout are not compared.
- R4: The ignore flags sit at match bits 37 (DIMM), 38 (rank), 39 (bank), 40 (page) and 41 (column). A set flag makes that field match any value.
- R5: Writing the control word (`cfg_sel`=2) arms the block when bit 3 or bit 4 is set, and disarms it otherwise. A matching write while disarmed produces no pulse.
- R6: When repeat (control bit 0) is clear, one injection fires and then `armed` drops. Later matching writes produce nothing.
- R7: When repeat is set, every matching write fires until the control word is rewritten with bits 4:3 zero.
- R8: On a fire, `flip_mask` equals the ECC mask register (`cfg_sel`=1) if control bit 3 is set and is zero otherwise. `parity_corrupt` equals control bit 4, and `half_sel` equals control bits 2:1 (bit 1 is the lower half, bit 2 the upper half). On cycles without a fire, all of these are zero.
- R9: `fired` goes high with the first injection, stays high, and clears on any control-word write.
- R10: On an ECC fire, `uncorrectable` is 1 exactly when the mask has set bits in more than one aligned 16-bit group.
- R11: Outputs appear one cycle after the matching write, as a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 match word, 1 ECC mask, 2 control |
| cfg_wdata | input | 42 | Register write data |
| three_dimm | input | 1 | Channel holds more than two DIMMs |
| wr_valid | input | 1 | A memory write is presented |
| wr_dimm | input | 2 | Decoded DIMM of the write |
| wr_rank | input | 2 | Decoded rank of the write |
| wr_bank | input | 4 | Decoded bank of the write |
| wr_page | input | 16 | Decoded page (row) of the write |
| wr_col | input | 14 | Decoded column of the write |
| inj_fire | output | 1 | Injection pulse |
| flip_mask | output | 32 | ECC bits to invert |
| parity_corrupt | output | 1 | Corrupt address parity |
| half_sel | output | 2 | Half-cacheline select |
| uncorrectable | output | 1 | Flip mask spans several symbol pairs |
| armed | output | 1 | Injection armed |
| fired | output | 1 | Sticky injection-happened status |

## Verification
Some properties are checked on every cycle. Every pulse needs a prior armed state. Outputs stay quiet between pulses. A one-shot fire always disarms the block and sets the sticky status. The sticky status clears only on a control write. The uncorrectable flag appears only on a pulse.

Other behaviour only shows in the bench scenarios. These cover the field placement in the match word, and how the rank/DIMM split follows the DIMM population. They also cover which ignore flag frees which field, the exact flip and parity values, and the grouping of mask bits into symbol pairs.

// File: rtl/fim_pkg.sv
package fim_pkg;
    typedef enum logic [1:0] {
        SEL_MATCH = 2'd0,
        SEL_ECC   = 2'd1,
        SEL_CTRL  = 2'd2
    } fim_sel_e;

    // control word: bit4 parity, bit3 ecc, bits2:1 half select, bit0 repeat
    typedef struct packed {
        logic       par;
        logic       ecc;
        logic [1:0] half;
        logic       rep;
    } fim_ctrl_t;

    localparam int CTRL_W = $bits(fim_ctrl_t);
endpackage

// File: rtl/fim_addr_match.sv
module fim_addr_match #(
    parameter int COL_W   = 14,
    parameter int PAGE_W  = 16,
    parameter int BANK_W  = 4,
    parameter int MATCH_W = COL_W + PAGE_W + BANK_W + 8
) (
    input  logic [MATCH_W-1:0] match_i,
    input  logic               three_i,
    input  logic [1:0]         dimm_i,
    input  logic [1:0]         rank_i,
    input  logic [BANK_W-1:0]  bank_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [COL_W-1:0]   col_i,
    output logic               hit_o
);
    localparam int PAGE_LO = COL_W;
    localparam int BANK_LO = PAGE_LO + PAGE_W;
    localparam int RANK_LO = BANK_LO + BANK_W;
    localparam int IGN_LO  = RANK_LO + 3;

    logic [4:0] ign;
    logic col_ok, page_ok, bank_ok, rank_ok, dimm_ok;

    always_comb begin
        ign     = match_i[IGN_LO +: 5];
        col_ok  = ign[4] | (match_i[0 +: COL_W] == col_i);
        page_ok = ign[3] | (match_i[PAGE_LO +: PAGE_W] == page_i);
        bank_ok = ign[2] | (match_i[BANK_LO +: BANK_W] == bank_i);
        if (three_i) begin
            rank_ok = ign[1] | (match_i[RANK_LO] == rank_i[0]);
            dimm_ok = ign[0] | (match_i[RANK_LO+1 +: 2] == dimm_i);
        end else begin
            rank_ok = ign[1] | (match_i[RANK_LO +: 2] == rank_i);
            dimm_ok = ign[0] | (match_i[RANK_LO+2] == dimm_i[0]);
        end
        hit_o = col_ok & page_ok & bank_ok & rank_ok & dimm_ok;
    end
endmodule

// File: rtl/fim_ecc_class.sv
module fim_ecc_class #(
    parameter int ECC_W  = 32,
    parameter int PAIR_W = 16
) (
    input  logic [ECC_W-1:0] mask_i,
    output logic             multi_o
);
    localparam int NGRP = ECC_W / PAIR_W;

    logic [NGRP-1:0] grp_nz;

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            assign grp_nz[g] = |mask_i[g*PAIR_W +: PAIR_W];
        end
    endgenerate

    assign multi_o = ($countones(grp_nz) > 1);
endmodule

// File: rtl/fim_ctrl.sv
module fim_ctrl
    import fim_pkg::*;
#(
    parameter int ECC_W   = 32,
    parameter int MATCH_W = 42
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [1:0]         cfg_sel_i,
    input  logic [MATCH_W-1:0] cfg_wdata_i,
    input  logic               wr_valid_i,
    input  logic               hit_i,
    input  logic               multi_i,
    output logic [MATCH_W-1:0] match_o,
    output logic [ECC_W-1:0]   ecc_o,
    output logic               fire_o,
    output logic [ECC_W-1:0]   flip_o,
    output logic               parity_o,
    output logic [1:0]         half_o,
    output logic               uncorr_o,
    output logic               armed_o,
    output logic               fired_o
);
    typedef struct packed {
        logic [MATCH_W-1:0] match;
        logic [ECC_W-1:0]   ecc;
        fim_ctrl_t          ctrl;
        logic               arm;
        logic               fired;
        logic               fire;
        logic [ECC_W-1:0]   flip;
        logic               par;
        logic [1:0]         half;
        logic               uncorr;
    } st_t;

    st_t st_d, st_q;
    logic take;

    always_comb begin
        st_d        = st_q;
        st_d.fire   = 1'b0;
        st_d.flip   = '0;
        st_d.par    = 1'b0;
        st_d.half   = '0;
        st_d.uncorr = 1'b0;
        take = wr_valid_i & hit_i & st_q.arm;
        if (take) begin
            st_d.fire   = 1'b1;
            st_d.flip   = st_q.ctrl.ecc ? st_q.ecc : '0;
            st_d.par    = st_q.ctrl.par;
            st_d.half   = st_q.ctrl.half;
            st_d.uncorr = st_q.ctrl.ecc & multi_i;
            st_d.fired  = 1'b1;
            if (!st_q.ctrl.rep) st_d.arm = 1'b0;
        end
        if (cfg_we_i) begin
            case (fim_sel_e'(cfg_sel_i))
                SEL_MATCH: st_d.match = cfg_wdata_i;
                SEL_ECC:   st_d.ecc   = cfg_wdata_i[ECC_W-1:0];
                SEL_CTRL: begin
                    st_d.ctrl  = fim_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
                    st_d.arm   = cfg_wdata_i[3] | cfg_wdata_i[4];
                    st_d.fired = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_o  = st_q.match;
    assign ecc_o    = st_q.ecc;
    assign fire_o   = st_q.fire;
    assign flip_o   = st_q.flip;
    assign parity_o = st_q.par;
    assign half_o   = st_q.half;
    assign uncorr_o = st_q.uncorr;
    assign armed_o  = st_q.arm;
    assign fired_o  = st_q.fired;

    // R5: a pulse needs the armed state in the cycle before
    a_r5_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(armed_o));

    // R6: a one-shot fire disarms and sets the sticky status
    a_r6_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && hit_i && armed_o && !st_q.ctrl.rep && !cfg_we_i)
        |=> (!armed_o && fired_o));

    // R8: nothing leaks out between pulses
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_o |-> (flip_o == '0 && !parity_o && half_o == 2'b00 && !uncorr_o));

    // R9: the sticky status clears only through a control write
    a_r9_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fired_o) |-> ($past(cfg_we_i) && $past(cfg_sel_i) == 2'd2));

    // R11: the pulse lasts one cycle unless another matching write follows
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !wr_valid_i) |=> !fire_o);
endmodule

// File: rtl/memfault_inject_unit.sv
module memfault_inject_unit #(
    parameter int COL_W   = 14,
    parameter int PAGE_W  = 16,
    parameter int BANK_W  = 4,
    parameter int ECC_W   = 32,
    parameter int PAIR_W  = 16,
    parameter int MATCH_W = COL_W + PAGE_W + BANK_W + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [MATCH_W-1:0] cfg_wdata,
    input  logic               three_dimm,
    input  logic               wr_valid,
    input  logic [1:0]         wr_dimm,
    input  logic [1:0]         wr_rank,
    input  logic [BANK_W-1:0]  wr_bank,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic [COL_W-1:0]   wr_col,
    output logic               inj_fire,
    output logic [ECC_W-1:0]   flip_mask,
    output logic               parity_corrupt,
    output logic [1:0]         half_sel,
    output logic               uncorrectable,
    output logic               armed,
    output logic               fired
);
    logic [MATCH_W-1:0] match_q;
    logic [ECC_W-1:0]   ecc_q;
    logic               hit, multi;

    fim_addr_match #(.COL_W(COL_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W),
                     .MATCH_W(MATCH_W)) u_match (
        .match_i(match_q), .three_i(three_dimm), .dimm_i(wr_dimm),
        .rank_i(wr_rank), .bank_i(wr_bank), .page_i(wr_page),
        .col_i(wr_col), .hit_o(hit)
    );

    fim_ecc_class #(.ECC_W(ECC_W), .PAIR_W(PAIR_W)) u_class (
        .mask_i(ecc_q), .multi_o(multi)
    );

    fim_ctrl #(.ECC_W(ECC_W), .MATCH_W(MATCH_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .wr_valid_i(wr_valid), .hit_i(hit),
        .multi_i(multi), .match_o(match_q), .ecc_o(ecc_q),
        .fire_o(inj_fire), .flip_o(flip_mask), .parity_o(parity_corrupt),
        .half_o(half_sel), .uncorr_o(uncorrectable), .armed_o(armed),
        .fired_o(fired)
    );

    // R10: the uncorrectable flag only accompanies a pulse
    a_r10_uncorr_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        uncorrectable |-> (inj_fire && flip_mask != '0));
endmodule

// File: tb/tb_memfault_inject_unit.sv
module tb_memfault_inject_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [41:0] cfg_wdata = '0;
    logic        three_dimm = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_dimm = '0, wr_rank = '0;
    logic [3:0]  wr_bank = '0;
    logic [15:0] wr_page = '0;
    logic [13:0] wr_col = '0;
    logic        inj_fire, parity_corrupt, uncorrectable, armed, fired;
    logic [31:0] flip_mask;
    logic [1:0]  half_sel;

    int n_chk = 0, n_err = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    memfault_inject_unit dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .three_dimm(three_dimm), .wr_valid(wr_valid),
        .wr_dimm(wr_dimm), .wr_rank(wr_rank), .wr_bank(wr_bank),
        .wr_page(wr_page), .wr_col(wr_col), .inj_fire(inj_fire),
        .flip_mask(flip_mask), .parity_corrupt(parity_corrupt),
        .half_sel(half_sel), .uncorrectable(uncorrectable), .armed(armed),
        .fired(fired)
    );

    typedef struct packed {
        logic        three;
        logic [4:0]  ign;
        logic [1:0]  md, mr;
        logic [3:0]  mb;
        logic [15:0] mp;
        logic [13:0] mc;
        logic [1:0]  wd, wr;
        logic [3:0]  wb;
        logic [15:0] wp;
        logic [13:0] wc;
        logic        exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 1'b1},
        '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abd, 1'b0},
        '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 2'd1, 2'd2, 4'd5, 16'h1235, 14'h0abc, 1'b0},
        '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 2'd1, 2'd2, 4'd6, 16'h1234, 14'h0abc, 1'b0},
        '{1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc, 2'd1, 2'd3, 4'd5, 16'h1234, 14'h0abc, 1'b0},
        '{1'b1, 5'h00, 2'd2, 2'd1, 4'd9, 16'h00ff, 14'h0011, 2'd2, 2'd1, 4'd9, 16'h00ff, 14'h0011, 1'b1},
        '{1'b1, 5'h00, 2'd2, 2'd1, 4'd9, 16'h00ff, 14'h0011, 2'd2, 2'd3, 4'd9, 16'h00ff, 14'h0011, 1'b1},
        '{1'b1, 5'h00, 2'd2, 2'd1, 4'd9, 16'h00ff, 14'h0011, 2'd1, 2'd1, 4'd9, 16'h00ff, 14'h0011, 1'b0},
        '{1'b0, 5'h00, 2'd1, 2'd0, 4'd3, 16'h0042, 14'h0100, 2'd3, 2'd0, 4'd3, 16'h0042, 14'h0100, 1'b1},
        '{1'b0, 5'h1f, 2'd0, 2'd0, 4'd0, 16'h0000, 14'h0000, 2'd3, 2'd3, 4'd15, 16'hbeef, 14'h3fff, 1'b1},
        '{1'b0, 5'h10, 2'd1, 2'd1, 4'd1, 16'h0001, 14'h0001, 2'd1, 2'd1, 4'd1, 16'h0001, 14'h2222, 1'b1},
        '{1'b0, 5'h08, 2'd1, 2'd1, 4'd1, 16'h0001, 14'h0001, 2'd1, 2'd1, 4'd2, 16'h7777, 14'h0001, 1'b0}
    };

    function automatic logic [41:0] mkword(logic three, logic [4:0] ign,
        logic [1:0] d, logic [1:0] r, logic [3:0] b, logic [15:0] p, logic [13:0] c);
        logic [41:0] w = '0;
        w[13:0]  = c;
        w[29:14] = p;
        w[33:30] = b;
        if (three) begin
            w[34]    = r[0];
            w[36:35] = d;
        end else begin
            w[35:34] = r;
            w[36]    = d[0];
        end
        w[41:37] = ign;
        return w;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] sel, logic [41:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic mwrite(logic [1:0] d, logic [1:0] r, logic [3:0] b,
                          logic [15:0] p, logic [13:0] c);
        @(negedge clk);
        wr_valid = 1'b1; wr_dimm = d; wr_rank = r; wr_bank = b; wr_page = p; wr_col = c;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_err++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [41:0] base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fire", inj_fire, 0);
        check("R1 flip", flip_mask, 0);
        check("R1 parity", parity_corrupt, 0);
        check("R1 half", half_sel, 0);
        check("R1 uncorr", uncorrectable, 0);
        check("R1 armed", armed, 0);
        check("R1 fired", fired, 0);

        // vector table: repeat mode, ecc injection, mask 0xF0
        cfg(2'd1, 42'h0000_00f0);
        cfg(2'd2, 42'h09);
        for (int i = 0; i < 12; i++) begin
            three_dimm = VEC[i].three;
            cfg(2'd0, mkword(VEC[i].three, VEC[i].ign, VEC[i].md, VEC[i].mr,
                             VEC[i].mb, VEC[i].mp, VEC[i].mc));
            mwrite(VEC[i].wd, VEC[i].wr, VEC[i].wb, VEC[i].wp, VEC[i].wc);
            check($sformatf("R2 R3 R4 vector %0d fire", i), inj_fire, VEC[i].exp);
            check($sformatf("R8 vector %0d flip", i), flip_mask,
                  VEC[i].exp ? 32'hf0 : 32'h0);
        end

        three_dimm = 1'b0;
        base = mkword(1'b0, 5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        cfg(2'd0, base);

        // R5 disarm by zero write, then non-arming control values
        cfg(2'd2, 42'h00);
        check("R5 armed after zero", armed, 0);
        mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        check("R5 no fire disarmed", inj_fire, 0);
        cfg(2'd2, 42'h07);
        check("R5 armed with bits 2:0 only", armed, 0);
        mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        check("R5 no fire bits 2:0 only", inj_fire, 0);

        // R6 R8 R11 one-shot parity injection, upper half
        cfg(2'd1, 42'h0000_00ff);
        cfg(2'd2, 42'h14);
        check("R5 armed by parity bit", armed, 1);
        mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        check("R11 fire after write", inj_fire, 1);
        check("R8 parity", parity_corrupt, 1);
        check("R8 flip zero without ecc bit", flip_mask, 0);
        check("R8 half select", half_sel, 2'b10);
        check("R6 disarmed", armed, 0);
        check("R9 fired set", fired, 1);
        @(negedge clk);
        check("R11 pulse ends", inj_fire, 0);
        check("R8 parity ends", parity_corrupt, 0);
        mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        check("R6 no second fire", inj_fire, 0);
        check("R9 fired sticky", fired, 1);

        // R9 cleared by control write; R10 correctable mask
        cfg(2'd1, 42'h0000_8001);
        cfg(2'd2, 42'h0a);
        check("R9 fired cleared", fired, 0);
        mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        check("R8 flip ecc", flip_mask, 32'h8001);
        check("R8 half lower", half_sel, 2'b01);
        check("R10 one pair correctable", uncorrectable, 0);

        // R7 repeat mode, R10 two pairs uncorrectable
        cfg(2'd1, 42'h0001_0001);
        cfg(2'd2, 42'h09);
        for (int k = 0; k < 3; k++) begin
            mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
            check($sformatf("R7 repeat fire %0d", k), inj_fire, 1);
            check("R10 two pairs uncorrectable", uncorrectable, 1);
            check("R7 still armed", armed, 1);
        end
        cfg(2'd2, 42'h01);
        check("R7 disarmed by clear", armed, 0);
        mwrite(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0abc);
        check("R7 no fire after clear", inj_fire, 0);

        finish_run();
    end
endmodule